// File: doc/BRIEF.md
# Interrupt Request Qualifier

This block merges two interrupt sources into one qualified request for a CPU core. The first source is a general interrupt controller. It holds a status vector and a mask vector. The second source is a DMA controller. It keeps a 16-bit status half and a 16-bit mask half in one 32-bit word. Each source reports pending when its status and mask overlap. The DMA source is also pending whenever its reserved "force" status bit is set, whatever the mask says.

A pending source reaches the core only when the coprocessor status state allows it. Its own master-enable bit must be on, and so must the global interrupt enable and the extended enable. The core must also be outside exception and error level. The block registers the request together with a cause mask for the exception unit. Bit 10 of the cause mask stands for the general controller and bit 11 for the DMA controller. All other cause bits stay zero, so the exception class field reads as "interrupt". A newly qualified request also produces a one-cycle kick, a fixed number of cycles later, that tells the event-check logic to run.

Status bits are set by hardware raise strobes and cleared by writing ones. Mask bits are written directly.

Top module: `irq_qualifier`

## Requirements
- R1: Following reset, every status and mask register reads zero, and `irq_req`, `cause_mask` and `event_kick` are all zero.
- R2: A one on `gen_raise[i]` sets general status bit i at the next edge. When `gen_clr_we` is high, each one in `gen_wdata` clears the matching status bit and zeros leave bits unchanged. A raise wins over a clear of the same bit in the same cycle.
- R3: When `gen_mask_we` is high, the general mask register takes the value of `gen_wdata` at the next edge.
- R4: When `dma_we` is high, each one in `dma_wdata[15:0]` clears the matching DMA status bit (`dma_word[15:0]`), and `dma_wdata[31:16]` replaces the DMA mask (`dma_word[31:16]`). `dma_raise[i]` sets DMA status bit i, and a raise wins over a clear.
- R5: The general source is pending only when general status AND general mask is non-zero.
- R6: The DMA source is pending when DMA status AND DMA mask is non-zero, or when DMA status bit 15 is set, even with a zero mask.
- R7: A pending source qualifies only when all of these hold: its master enable is 1 (`st_gen_en` for the general source, `st_dma_en` for DMA), `st_ie` is 1, `st_eie` is 1, `st_exl` is 0 and `st_erl` is 0.
- R8: `irq_req` and `cause_mask` are registered and follow the register and status state of the previous cycle. `cause_mask` has bit 10 set for a qualified general source and bit 11 set for a qualified DMA source. Every other bit is zero.
- R9: `irq_req` is low in the cycle after the one in which `st_exl` is high.
- R10: When `irq_req` rises, `event_kick` pulses high for exactly one cycle, 4 clock edges later. A new rise before the pulse restarts the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_ie | input | 1 | Global interrupt enable from the status register |
| st_eie | input | 1 | Extended interrupt enable |
| st_exl | input | 1 | Exception level active |
| st_erl | input | 1 | Error level active |
| st_gen_en | input | 1 | Master enable for the general controller source |
| st_dma_en | input | 1 | Master enable for the DMA source |
| gen_raise | input | GEN_W | Hardware set strobes for general status bits |
| gen_clr_we | input | 1 | Write-one-to-clear strobe for general status |
| gen_mask_we | input | 1 | Write strobe for the general mask |
| gen_wdata | input | GEN_W | Write data for general status clear and mask write |
| dma_raise | input | DMA_HALF | Hardware set strobes for DMA status bits |
| dma_we | input | 1 | Write strobe for the DMA word |
| dma_wdata | input | 2*DMA_HALF | Low half clears status, high half writes the mask |
| gen_stat | output | GEN_W | General status register |
| gen_mask | output | GEN_W | General mask register |
| dma_word | output | 2*DMA_HALF | DMA mask (high half) and status (low half) |
| irq_req | output | 1 | Qualified interrupt request, registered |
| cause_mask | output | 32 | Cause bits handed to the exception unit |
| event_kick | output | 1 | One-cycle request to run the event check |

## Verification
The write and raise properties compare each register with the previous cycle's strobes and data. They therefore assume that every strobe is low during reset. The stimulus holds all inputs at zero until reset has been released. The status-bit inputs are treated as levels that can change on any cycle. The stimulus changes them only between clock edges, away from the sampling edge, so each property sees one stable value per cycle. Raise strobes are pulsed for single cycles, except in the deliberate raise-against-clear collision case.

// File: rtl/irq_qual_pkg.sv
package irq_qual_pkg;
  // Cause bit positions handed to the exception unit; the class field (6:2) stays zero.
  localparam int CAUSE_W       = 32;
  localparam int CAUSE_GEN_BIT = 10;
  localparam int CAUSE_DMA_BIT = 11;

  typedef struct packed {
    logic ie;
    logic eie;
    logic exl;
    logic erl;
    logic gen_en;
    logic dma_en;
  } stat_ctl_t;
endpackage

// File: rtl/gen_src.sv
module gen_src #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raise_i,
  input  logic         clr_we_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] mask_o,
  output logic         pend_o
);
  logic [W-1:0] stat_q;
  logic [W-1:0] mask_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        stat_q[i] <= 1'b0;
      else if (raise_i[i])
        stat_q[i] <= 1'b1;
      else if (clr_we_i && wdata_i[i])
        stat_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      mask_q <= '0;
    else if (mask_we_i)
      mask_q <= wdata_i;
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign pend_o = |(stat_q & mask_q);

  assert_raise_sets_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & $past(raise_i)) == $past(raise_i)));

  assert_mask_write_R3: assert property (@(posedge clk) disable iff (rst)
    mask_we_i |=> (mask_q == $past(wdata_i)));
endmodule

// File: rtl/dma_src.sv
module dma_src #(
  parameter int HALF      = 16,
  parameter int FORCE_BIT = 15,
  localparam int WW       = 2 * HALF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [HALF-1:0] raise_i,
  input  logic            we_i,
  input  logic [WW-1:0]   wdata_i,
  output logic [WW-1:0]   word_o,
  output logic            pend_o
);
  logic [HALF-1:0] stat_q;
  logic [HALF-1:0] mask_q;

  for (genvar i = 0; i < HALF; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        stat_q[i] <= 1'b0;
      else if (raise_i[i])
        stat_q[i] <= 1'b1;
      else if (we_i && wdata_i[i])
        stat_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      mask_q <= '0;
    else if (we_i)
      mask_q <= wdata_i[WW-1:HALF];
  end

  assign word_o = {mask_q, stat_q};
  assign pend_o = (|(stat_q & mask_q)) | stat_q[FORCE_BIT];

  assert_mask_half_R4: assert property (@(posedge clk) disable iff (rst)
    we_i |=> (word_o[WW-1:HALF] == $past(wdata_i[WW-1:HALF])));

  assert_raise_sets_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((word_o[HALF-1:0] & $past(raise_i)) == $past(raise_i)));
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_qual_pkg::*;
#(
  parameter int DELAY = 4,
  localparam int CNT_W = $clog2(DELAY + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  stat_ctl_t          ctl_i,
  input  logic               gen_pend_i,
  input  logic               dma_pend_i,
  output logic               irq_req_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               kick_o
);
  logic               glob_ok;
  logic               gen_q_c;
  logic               dma_q_c;
  logic               qual_c;
  logic [CAUSE_W-1:0] cause_c;
  logic [CNT_W-1:0]   cnt_q;

  assign glob_ok = ctl_i.ie && ctl_i.eie && !ctl_i.exl && !ctl_i.erl;
  assign gen_q_c = glob_ok && ctl_i.gen_en && gen_pend_i;
  assign dma_q_c = glob_ok && ctl_i.dma_en && dma_pend_i;
  assign qual_c  = gen_q_c || dma_q_c;

  always_comb begin
    cause_c = '0;
    cause_c[CAUSE_GEN_BIT] = gen_q_c;
    cause_c[CAUSE_DMA_BIT] = dma_q_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req_o <= 1'b0;
      cause_o   <= '0;
    end else begin
      irq_req_o <= qual_c;
      cause_o   <= cause_c;
    end
  end

  // Deferred event check: loads on a fresh qualification, fires when the count runs out.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      kick_o <= 1'b0;
    end else begin
      kick_o <= 1'b0;
      if (qual_c && !irq_req_o) begin
        cnt_q <= CNT_W'(DELAY);
      end else if (cnt_q != '0) begin
        cnt_q  <= cnt_q - 1'b1;
        kick_o <= (cnt_q == CNT_W'(1));
      end
    end
  end

  assert_exl_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    ctl_i.exl |=> !irq_req_o);

  assert_global_gate_R7: assert property (@(posedge clk) disable iff (rst)
    irq_req_o |-> $past(ctl_i.ie && ctl_i.eie && !ctl_i.erl));

  assert_gen_cause_R8: assert property (@(posedge clk) disable iff (rst)
    cause_o[CAUSE_GEN_BIT] |-> $past(gen_pend_i && ctl_i.gen_en));

  assert_dma_cause_R8: assert property (@(posedge clk) disable iff (rst)
    cause_o[CAUSE_DMA_BIT] |-> $past(dma_pend_i && ctl_i.dma_en));

  assert_kick_single_R10: assert property (@(posedge clk) disable iff (rst)
    kick_o |=> !kick_o);
endmodule

// File: rtl/irq_qualifier.sv
module irq_qualifier
  import irq_qual_pkg::*;
#(
  parameter int GEN_W     = 16,
  parameter int DMA_HALF  = 16,
  parameter int FORCE_BIT = 15,
  parameter int DELAY     = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  st_ie,
  input  logic                  st_eie,
  input  logic                  st_exl,
  input  logic                  st_erl,
  input  logic                  st_gen_en,
  input  logic                  st_dma_en,
  input  logic [GEN_W-1:0]      gen_raise,
  input  logic                  gen_clr_we,
  input  logic                  gen_mask_we,
  input  logic [GEN_W-1:0]      gen_wdata,
  input  logic [DMA_HALF-1:0]   dma_raise,
  input  logic                  dma_we,
  input  logic [2*DMA_HALF-1:0] dma_wdata,
  output logic [GEN_W-1:0]      gen_stat,
  output logic [GEN_W-1:0]      gen_mask,
  output logic [2*DMA_HALF-1:0] dma_word,
  output logic                  irq_req,
  output logic [CAUSE_W-1:0]    cause_mask,
  output logic                  event_kick
);
  stat_ctl_t ctl;
  logic      gen_pend;
  logic      dma_pend;

  assign ctl = '{ie: st_ie, eie: st_eie, exl: st_exl, erl: st_erl,
                 gen_en: st_gen_en, dma_en: st_dma_en};

  gen_src #(.W(GEN_W)) u_gen (
    .clk(clk), .rst(rst), .raise_i(gen_raise), .clr_we_i(gen_clr_we),
    .mask_we_i(gen_mask_we), .wdata_i(gen_wdata),
    .stat_o(gen_stat), .mask_o(gen_mask), .pend_o(gen_pend)
  );

  dma_src #(.HALF(DMA_HALF), .FORCE_BIT(FORCE_BIT)) u_dma (
    .clk(clk), .rst(rst), .raise_i(dma_raise), .we_i(dma_we),
    .wdata_i(dma_wdata), .word_o(dma_word), .pend_o(dma_pend)
  );

  irq_gate #(.DELAY(DELAY)) u_gate (
    .clk(clk), .rst(rst), .ctl_i(ctl), .gen_pend_i(gen_pend),
    .dma_pend_i(dma_pend), .irq_req_o(irq_req), .cause_o(cause_mask),
    .kick_o(event_kick)
  );
endmodule

// File: tb/irq_qualifier_tb.sv
module irq_qualifier_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        st_ie = 0, st_eie = 0, st_exl = 0, st_erl = 0, st_gen_en = 0, st_dma_en = 0;
  logic [15:0] gen_raise = '0;
  logic        gen_clr_we = 0, gen_mask_we = 0;
  logic [15:0] gen_wdata = '0;
  logic [15:0] dma_raise = '0;
  logic        dma_we = 0;
  logic [31:0] dma_wdata = '0;
  logic [15:0] gen_stat, gen_mask;
  logic [31:0] dma_word;
  logic        irq_req;
  logic [31:0] cause_mask;
  logic        event_kick;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_qualifier dut_i (
    .clk(clk), .rst(rst), .st_ie(st_ie), .st_eie(st_eie), .st_exl(st_exl),
    .st_erl(st_erl), .st_gen_en(st_gen_en), .st_dma_en(st_dma_en),
    .gen_raise(gen_raise), .gen_clr_we(gen_clr_we), .gen_mask_we(gen_mask_we),
    .gen_wdata(gen_wdata), .dma_raise(dma_raise), .dma_we(dma_we),
    .dma_wdata(dma_wdata), .gen_stat(gen_stat), .gen_mask(gen_mask),
    .dma_word(dma_word), .irq_req(irq_req), .cause_mask(cause_mask),
    .event_kick(event_kick)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic enable_all();
    st_ie = 1; st_eie = 1; st_exl = 0; st_erl = 0; st_gen_en = 1; st_dma_en = 1;
  endtask

  task automatic clean();
    gen_clr_we = 1; gen_mask_we = 1; gen_wdata = 16'hFFFF;
    dma_we = 1; dma_wdata = 32'h0000_FFFF;
    step(1);
    gen_clr_we = 0; gen_mask_we = 0; gen_wdata = '0; dma_we = 0; dma_wdata = '0;
    gen_mask_we = 1; step(1); gen_mask_we = 0;
    step(2);
  endtask

  task automatic t_reset();
    chk("R1 gen_stat", gen_stat, 0);
    chk("R1 gen_mask", gen_mask, 0);
    chk("R1 dma_word", dma_word, 0);
    chk("R1 irq_req", irq_req, 0);
    chk("R1 cause", cause_mask, 0);
    chk("R1 kick", event_kick, 0);
  endtask

  task automatic t_gen_regs();
    gen_raise = 16'h00A5; step(1); gen_raise = '0;
    chk("R2 raise", gen_stat, 32'h00A5);
    gen_clr_we = 1; gen_wdata = 16'h0021; step(1); gen_clr_we = 0;
    chk("R2 w1c", gen_stat, 32'h0084);
    gen_clr_we = 1; gen_wdata = 16'h0004; gen_raise = 16'h0004; step(1);
    gen_clr_we = 0; gen_raise = '0;
    chk("R2 raise wins", gen_stat, 32'h0084);
    gen_mask_we = 1; gen_wdata = 16'h3C0F; step(1); gen_mask_we = 0;
    chk("R3 mask write", gen_mask, 32'h3C0F);
    chk("R3 status untouched", gen_stat, 32'h0084);
    clean();
  endtask

  task automatic t_dma_regs();
    dma_raise = 16'h0C03; step(1); dma_raise = '0;
    chk("R4 raise", dma_word, 32'h0000_0C03);
    dma_we = 1; dma_wdata = 32'h5A5A_0401; step(1); dma_we = 0;
    chk("R4 w1c and mask", dma_word, 32'h5A5A_0802);
    clean();
  endtask

  task automatic t_gen_pending();
    enable_all();
    gen_raise = 16'h0010; step(1); gen_raise = '0; step(1);
    chk("R5 no mask overlap", irq_req, 0);
    gen_mask_we = 1; gen_wdata = 16'h0020; step(2); gen_mask_we = 0;
    chk("R5 disjoint mask", irq_req, 0);
    gen_mask_we = 1; gen_wdata = 16'h0030; step(1); gen_mask_we = 0;
    step(1);
    chk("R5 overlap irq", irq_req, 1);
    chk("R8 gen cause", cause_mask, 32'h0000_0400);
    st_gen_en = 0; step(1);
    chk("R7 gen master off", irq_req, 0);
    st_gen_en = 1;
    clean();
  endtask

  task automatic t_dma_pending();
    enable_all();
    dma_raise = 16'h8000; step(1); dma_raise = '0; step(1);
    chk("R6 force bit no mask", irq_req, 1);
    chk("R8 dma cause", cause_mask, 32'h0000_0800);
    dma_we = 1; dma_wdata = 32'h0000_8000; step(1); dma_we = 0; step(1);
    chk("R6 force cleared", irq_req, 0);
    dma_raise = 16'h0002; step(1); dma_raise = '0; step(1);
    chk("R6 no overlap", irq_req, 0);
    dma_we = 1; dma_wdata = 32'h0002_0000; step(1); dma_we = 0; step(1);
    chk("R6 overlap", irq_req, 1);
    gen_raise = 16'h0001; gen_mask_we = 1; gen_wdata = 16'h0001; step(1);
    gen_raise = '0; gen_mask_we = 0; step(1);
    chk("R8 both causes", cause_mask, 32'h0000_0C00);
    st_dma_en = 0; step(1);
    chk("R7 dma master off", cause_mask, 32'h0000_0400);
    enable_all();
    clean();
  endtask

  task automatic t_gating();
    enable_all();
    gen_raise = 16'h0001; gen_mask_we = 1; gen_wdata = 16'h0001; step(1);
    gen_raise = '0; gen_mask_we = 0; step(1);
    chk("R7 all enabled", irq_req, 1);
    st_ie = 0; step(1); chk("R7 ie off", irq_req, 0); st_ie = 1; step(1);
    st_eie = 0; step(1); chk("R7 eie off", irq_req, 0); st_eie = 1; step(1);
    st_erl = 1; step(1); chk("R7 erl on", irq_req, 0); st_erl = 0; step(1);
    chk("R7 re-enabled", irq_req, 1);
    clean();
  endtask

  task automatic t_exl_drop();
    enable_all();
    gen_raise = 16'h0002; gen_mask_we = 1; gen_wdata = 16'h0002; step(1);
    gen_raise = '0; gen_mask_we = 0; step(1);
    chk("R9 before exl", irq_req, 1);
    st_exl = 1; step(1);
    chk("R9 dropped after exl", irq_req, 0);
    chk("R9 cause cleared", cause_mask, 0);
    st_exl = 0; step(1);
    chk("R9 back after exl clear", irq_req, 1);
    clean();
  endtask

  task automatic t_kick();
    enable_all();
    gen_mask_we = 1; gen_wdata = 16'h0008; step(1); gen_mask_we = 0;
    step(6);
    gen_raise = 16'h0008; step(1); gen_raise = '0;
    step(1);
    chk("R10 irq rose", irq_req, 1);
    chk("R10 no kick yet", event_kick, 0);
    step(3);
    chk("R10 kick not early", event_kick, 0);
    step(1);
    chk("R10 kick at delay", event_kick, 1);
    step(1);
    chk("R10 kick one cycle", event_kick, 0);
    clean();
    step(6);
  endtask

  initial begin : watchdog
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst = 0;
    step(1);
    t_reset();
    t_gen_regs();
    t_dma_regs();
    t_gen_pending();
    t_dma_pending();
    t_gating();
    t_exl_drop();
    t_kick();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule